// File: doc/BRIEF.md
# Supply Fault and Hiccup Sequencer

This block supervises the supply of a current-mode switching controller and decides when the gate driver may switch. It takes a digitised supply voltage code, a per-cycle current-limit flag, an over-temperature flag and a strobe that marks the end of each switching cycle. From these it produces a driver enable, a request to hold the gate actively low, a prioritised fault code and a one-cycle restart pulse.

Undervoltage lockout uses two thresholds. The block leaves lockout when the code reaches the turn-on level and enters it again when the code falls to the turn-off level. Sustained overload is timed in switching cycles: a run of current-limited cycles without a break is counted. An over-voltage level is qualified by a deglitch window counted in clock cycles. Overload and over-voltage faults latch the driver off. They clear only when the supply collapses into lockout, so the converter recovers by hiccup: each climb back through the turn-on level pulses `restart` to begin a fresh soft start. Over-temperature is not latched. It blocks switching only while its flag is high.

Top module: `supply_fault_seq`

## Requirements
- R1: After synchronous reset, `drv_en`=0, `gate_pull_low`=1, `fault_code`=1 (UVLO) and `restart`=0.
- R2: In lockout, a clock edge that samples `vdd_code` >= `VDD_ON_CODE` leaves lockout on that edge. `gate_pull_low` falls, `restart` is 1 for exactly one cycle, and `drv_en` rises unless another fault is active.
- R3: Lockout has hysteresis. Outside lockout, only `vdd_code` <= `VDD_OFF_CODE` enters it. Inside lockout, any code below `VDD_ON_CODE` keeps it there.
- R4: Outside lockout, on the edge that samples the `OLP_CYCLES`-th consecutive `cyc_stb` with `ilim_hit`=1, the overload fault latches. `drv_en` goes to 0 on that edge.
- R5: A `cyc_stb` with `ilim_hit`=0 restarts the overload count from zero. `ilim_hit` without `cyc_stb` does not advance the count.
- R6: The over-voltage fault latches on the edge that samples `vdd_code` >= `VDD_OVP_CODE` for the `OVP_DGL_CLKS`-th consecutive clock. A shorter excursion has no effect.
- R7: While `ot_flag`=1, `drv_en` is 0 from the next edge on. When the flag clears and nothing is latched, `drv_en` returns one edge later.
- R8: A latched overload or over-voltage fault keeps `drv_en` at 0 at any supply code until the block enters lockout. Entering lockout clears both latches, so the next exit from lockout enables the driver again.
- R9: `fault_code` shows the highest-priority active condition with this encoding: 4 over-voltage, 3 over-temperature, 2 overload, 1 lockout, 0 none. `drv_en`=1 exactly when the code is 0.
- R10: `gate_pull_low` is 1 exactly while in lockout, and `drv_en` is never 1 together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_code | input | VDD_W | Digitised supply voltage |
| ilim_hit | input | 1 | Current limit reached in the cycle ending at `cyc_stb` |
| ot_flag | input | 1 | Over-temperature comparator output (hysteresis applied upstream) |
| cyc_stb | input | 1 | One-clock pulse at the end of each switching cycle |
| drv_en | output | 1 | Gate driver may switch |
| gate_pull_low | output | 1 | Hold the gate actively low |
| fault_code | output | 3 | Prioritised fault code |
| restart | output | 1 | One-cycle pulse on each exit from lockout |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume that `cyc_stb` is a single-clock pulse and that `ilim_hit` matters only on a strobe clock. The stimulus sets every input half a period before the sampling edge. Strobes are drawn about one clock in four, with the current limit mostly set on those clocks so that overload runs do form. The supply code follows a bounded random walk, mixed with jumps to values on either side of each threshold. This keeps both hysteresis edges and the over-voltage window in play.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_UVLO = 3'd1,
    FC_OLP  = 3'd2,
    FC_OTP  = 3'd3,
    FC_OVP  = 3'd4
  } fault_e;

  // Highest priority first: over-voltage, over-temperature, overload, lockout
  function automatic fault_e fault_pick(input logic ovp, input logic otp,
                                        input logic olp, input logic lock);
    if (ovp)       return FC_OVP;
    else if (otp)  return FC_OTP;
    else if (olp)  return FC_OLP;
    else if (lock) return FC_UVLO;
    else           return FC_NONE;
  endfunction

endpackage

// File: rtl/sfs_uvlo.sv
module sfs_uvlo #(
  parameter int VDD_W        = 10,
  parameter int VDD_ON_CODE  = 140,
  parameter int VDD_OFF_CODE = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VDD_W-1:0] vdd_code,
  output logic             lock_d,
  output logic             lock_q
);

  localparam logic [VDD_W-1:0] ON_C  = VDD_W'(VDD_ON_CODE);
  localparam logic [VDD_W-1:0] OFF_C = VDD_W'(VDD_OFF_CODE);

  // Two thresholds give the hysteresis band
  always_comb begin
    if (lock_q) lock_d = (vdd_code < ON_C);
    else        lock_d = (vdd_code <= OFF_C);
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b1;
    else     lock_q <= lock_d;
  end

endmodule

// File: rtl/sfs_run_counter.sv
module sfs_run_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic hit,
  output logic trip
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Trip on the event that completes an unbroken run of LIMIT hits
  assign trip = !clr && adv && hit && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt_q <= '0;
    else if (adv) begin
      if (!hit || trip) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq
  import sfs_pkg::*;
#(
  parameter int VDD_W        = 10,
  parameter int VDD_ON_CODE  = 140,
  parameter int VDD_OFF_CODE = 100,
  parameter int VDD_OVP_CODE = 270,
  parameter int OLP_CYCLES   = 4096,
  parameter int OVP_DGL_CLKS = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VDD_W-1:0] vdd_code,
  input  logic             ilim_hit,
  input  logic             ot_flag,
  input  logic             cyc_stb,
  output logic             drv_en,
  output logic             gate_pull_low,
  output logic [2:0]       fault_code,
  output logic             restart
);

  localparam logic [VDD_W-1:0] OVP_C = VDD_W'(VDD_OVP_CODE);

  logic lock_d, lock_q;
  logic ovp_trip, olp_trip;
  logic ovp_lat_q, olp_lat_q, ovp_lat_d, olp_lat_d;
  logic drv_d, restart_d;
  fault_e fault_d;

  sfs_uvlo #(
    .VDD_W(VDD_W), .VDD_ON_CODE(VDD_ON_CODE), .VDD_OFF_CODE(VDD_OFF_CODE)
  ) u_uvlo (
    .clk(clk), .rst(rst), .vdd_code(vdd_code), .lock_d(lock_d), .lock_q(lock_q)
  );

  // Over-voltage deglitch: counted every clock while above the level
  sfs_run_counter #(.LIMIT(OVP_DGL_CLKS)) u_ovp_dgl (
    .clk(clk), .rst(rst), .clr(lock_d), .adv(1'b1),
    .hit(vdd_code >= OVP_C), .trip(ovp_trip)
  );

  // Overload timer: counted in current-limited switching cycles
  sfs_run_counter #(.LIMIT(OLP_CYCLES)) u_olp_tmr (
    .clk(clk), .rst(rst), .clr(lock_d), .adv(cyc_stb),
    .hit(ilim_hit), .trip(olp_trip)
  );

  always_comb begin
    ovp_lat_d = !lock_d && (ovp_lat_q || ovp_trip);
    olp_lat_d = !lock_d && (olp_lat_q || olp_trip);
    drv_d     = !lock_d && !ovp_lat_d && !olp_lat_d && !ot_flag;
    restart_d = lock_q && !lock_d;
    fault_d   = fault_pick(ovp_lat_d, ot_flag, olp_lat_d, lock_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovp_lat_q     <= 1'b0;
      olp_lat_q     <= 1'b0;
      drv_en        <= 1'b0;
      gate_pull_low <= 1'b1;
      fault_code    <= FC_UVLO;
      restart       <= 1'b0;
    end else begin
      ovp_lat_q     <= ovp_lat_d;
      olp_lat_q     <= olp_lat_d;
      drv_en        <= drv_d;
      gate_pull_low <= lock_d;
      fault_code    <= fault_d;
      restart       <= restart_d;
    end
  end

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import sfs_pkg::*;
#(
  parameter int VDD_W        = 10,
  parameter int VDD_ON_CODE  = 140,
  parameter int VDD_OFF_CODE = 100,
  parameter int VDD_OVP_CODE = 270
) (
  input logic             clk,
  input logic             rst,
  input logic [VDD_W-1:0] vdd_code,
  input logic             ilim_hit,
  input logic             ot_flag,
  input logic             cyc_stb,
  input logic             drv_en,
  input logic             gate_pull_low,
  input logic [2:0]       fault_code,
  input logic             restart
);

  localparam logic [VDD_W-1:0] ON_C  = VDD_W'(VDD_ON_CODE);
  localparam logic [VDD_W-1:0] OFF_C = VDD_W'(VDD_OFF_CODE);
  localparam logic [VDD_W-1:0] OVP_C = VDD_W'(VDD_OVP_CODE);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_pull_low && !drv_en && !restart));

  p_exit_lock_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_pull_low) |-> ($past(vdd_code) >= ON_C && restart));

  p_restart_once_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart);

  p_enter_lock_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_pull_low) |-> ($past(vdd_code) <= OFF_C));

  p_olp_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (fault_code == FC_OLP && $past(fault_code) == FC_NONE)
      |-> $past(cyc_stb && ilim_hit));

  p_ovp_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_code == FC_OVP && $past(fault_code) != FC_OVP)
      |-> ($past(vdd_code) >= OVP_C));

  p_otp_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> (!drv_en && fault_code != FC_NONE));

  p_latched_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_code == FC_OVP || fault_code == FC_OLP) |=> !drv_en);

  p_code_range_r9: assert property (@(posedge clk) disable iff (rst)
    fault_code <= 3'd4);

  p_enable_matches_code_r9: assert property (@(posedge clk) disable iff (rst)
    drv_en == (fault_code == FC_NONE));

  p_pull_low_excl_r10: assert property (@(posedge clk) disable iff (rst)
    gate_pull_low |-> (!drv_en && fault_code != FC_NONE));

endmodule

bind supply_fault_seq sfs_checker #(
  .VDD_W(VDD_W), .VDD_ON_CODE(VDD_ON_CODE),
  .VDD_OFF_CODE(VDD_OFF_CODE), .VDD_OVP_CODE(VDD_OVP_CODE)
) u_sfs_checker (
  .clk(clk), .rst(rst), .vdd_code(vdd_code), .ilim_hit(ilim_hit),
  .ot_flag(ot_flag), .cyc_stb(cyc_stb), .drv_en(drv_en),
  .gate_pull_low(gate_pull_low), .fault_code(fault_code), .restart(restart)
);

// File: tb/supply_fault_seq_bench.sv
module supply_fault_seq_bench;

  localparam int VW   = 10;
  localparam int ON   = 140;
  localparam int OFF  = 100;
  localparam int OVP  = 270;
  localparam int OLPN = 16;
  localparam int DGLN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VW-1:0] vdd_code = '0;
  logic ilim_hit = 1'b0, ot_flag = 1'b0, cyc_stb = 1'b0;
  logic drv_en, gate_pull_low, restart;
  logic [2:0] fault_code;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Reference state taken from the requirements
  bit m_lock, m_ovp, m_olp, m_drv, m_pl, m_rst;
  int m_ovc, m_olc, m_fc;

  always #2 clk = ~clk;

  supply_fault_seq #(
    .VDD_W(VW), .VDD_ON_CODE(ON), .VDD_OFF_CODE(OFF), .VDD_OVP_CODE(OVP),
    .OLP_CYCLES(OLPN), .OVP_DGL_CLKS(DGLN)
  ) u_supply_fault_seq (
    .clk(clk), .rst(rst), .vdd_code(vdd_code), .ilim_hit(ilim_hit),
    .ot_flag(ot_flag), .cyc_stb(cyc_stb), .drv_en(drv_en),
    .gate_pull_low(gate_pull_low), .fault_code(fault_code), .restart(restart)
  );

  // R9 encoding and priority
  function automatic int exp_code(bit ovp, bit ot, bit olp, bit lock);
    if (ovp) return 4;
    if (ot) return 3;
    if (olp) return 2;
    if (lock) return 1;
    return 0;
  endfunction

  function automatic bit exp_lock(bit lock, int v);
    return lock ? (v < ON) : (v <= OFF);   // R3 hysteresis, R2 exit
  endfunction

  task automatic model_reset();
    m_lock = 1; m_ovp = 0; m_olp = 0; m_ovc = 0; m_olc = 0;
    m_drv = 0; m_pl = 1; m_rst = 0; m_fc = 1;
  endtask

  task automatic model_edge();
    bit nl;
    int v;
    v  = int'(vdd_code);
    nl = exp_lock(m_lock, v);
    m_rst = m_lock && !nl;
    if (nl) begin
      m_ovc = 0; m_olc = 0; m_ovp = 0; m_olp = 0;   // R8 cleared by lockout
    end else begin
      if (v >= OVP) begin                           // R6
        if (m_ovc == DGLN - 1) begin m_ovp = 1; m_ovc = 0; end
        else m_ovc++;
      end else m_ovc = 0;
      if (cyc_stb) begin                            // R4, R5
        if (!ilim_hit) m_olc = 0;
        else if (m_olc == OLPN - 1) begin m_olp = 1; m_olc = 0; end
        else m_olc++;
      end
    end
    m_lock = nl;
    m_drv  = !nl && !m_ovp && !m_olp && !ot_flag;   // R7
    m_pl   = nl;                                    // R10
    m_fc   = exp_code(m_ovp, ot_flag, m_olp, nl);
  endtask

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "drv_en", int'(drv_en), int'(m_drv));
    chk(tag, "gate_pull_low", int'(gate_pull_low), int'(m_pl));
    chk(tag, "fault_code", int'(fault_code), m_fc);
    chk(tag, "restart", int'(restart), int'(m_rst));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic strobe(input bit lim, input string tag);
    cyc_stb = 1; ilim_hit = lim; step(tag);
    cyc_stb = 0; ilim_hit = 0; steps(2, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1 reset state");

    vdd_code = 139; steps(3, "R3 below turn-on stays locked");
    vdd_code = 140; step("R2 exit at turn-on with restart");
    step("R2 restart single cycle");
    vdd_code = 101; steps(2, "R3 above turn-off stays running");

    // R5: broken run of limited cycles never trips
    for (int i = 0; i < OLPN - 1; i++) strobe(1, "R5 limited run");
    strobe(0, "R5 clean cycle clears count");
    ilim_hit = 1; steps(3, "R5 limit without strobe ignored"); ilim_hit = 0;
    for (int i = 0; i < OLPN - 1; i++) strobe(1, "R5 count restarted");
    strobe(1, "R4 overload trip");
    vdd_code = 200; steps(3, "R8 overload latched at mid supply");
    ot_flag = 1; step("R9 otp over olp"); ot_flag = 0; step("R8 olp still latched");
    vdd_code = 100; step("R8 lockout clears latch");
    vdd_code = 140; step("R8 hiccup restart");
    steps(2, "R8 running after restart");

    // R6 deglitch
    vdd_code = 270; steps(DGLN - 1, "R6 short excursion");
    vdd_code = 269; steps(2, "R6 excursion ignored");
    vdd_code = 275; steps(DGLN, "R6 qualified over-voltage");
    ot_flag = 1; steps(2, "R9 ovp over otp"); ot_flag = 0;
    vdd_code = 150; steps(2, "R8 ovp latched");
    vdd_code = 90; step("R3 into lockout");
    ot_flag = 1; steps(2, "R9 otp over uvlo");
    vdd_code = 145; steps(2, "R7 otp blocks after exit"); ot_flag = 0;
    steps(2, "R7 resumes after otp clears");
    ot_flag = 1; step("R7 otp one clock"); ot_flag = 0; step("R7 recover");

    // Random phase
    v = 140;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 40 == 0) begin
        case ($urandom % 7)
          0: v = 99; 1: v = 100; 2: v = 101; 3: v = 139;
          4: v = 140; 5: v = 270; default: v = 280;
        endcase
      end else begin
        v = v + int'($urandom % 21) - 10;
        if (v < 0) v = 0;
        if (v > 300) v = 300;
      end
      vdd_code = VW'(v);
      cyc_stb  = ($urandom % 4) == 0;
      ilim_hit = cyc_stb ? (($urandom % 10) != 0) : ($urandom % 2 == 0);
      if ($urandom % 60 == 0) ot_flag = ~ot_flag;
      step("random R4 R6 R7 R8 R10");
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule